// File: doc/BRIEF.md
# Receive Character Queue with Error Tracking

This block buffers received characters between a serial receiver and a host. Each stored entry holds an 8-bit character and three error flags for that character: break, framing and parity. The queue is first-in first-out, 64 entries deep by default. It always presents the character at its head, together with that character's own error flags, so the host sees the data and its error status side by side.

The block also keeps a summary error flag. The flag is high while any character still held in the queue has at least one error flag set. Reading one erroneous character does not clear it. It drops only after the last erroneous character has left the queue.

A receiver pushes entries with a write strobe, and the host pops them with a read strobe. Both strobes may be active in the same cycle. A write into a full queue is discarded and reported by a one-cycle overflow pulse. A read from an empty queue does nothing.

Top module: `rxq_err_fifo`

## Requirements
- R1: Characters leave in the order they were accepted. `level` counts stored entries, from 0 up to DEPTH (64).
- R2: `empty` is high exactly when `level` is 0, and `full` is high exactly when `level` equals DEPTH.
- R3: A write while `full` is high is discarded and the contents are unchanged. `ovf` is high for exactly the one cycle after each discarded write and low otherwise.
- R4: A read while `empty` is high is ignored: `level`, `empty` and the head outputs stay as they were.
- R5: If a write is accepted and a read is accepted in the same cycle, `level` is unchanged and the written character joins the tail.
- R6: `head_flags` carries the flags of the character at the head: bit 2 is break, bit 1 is framing error, bit 0 is parity error. After a read it shows the flags of the next entry.
- R7: While the queue is empty, `head_data` and `head_flags` are all zero.
- R8: `err_any` is high whenever at least one stored entry has any flag bit set. It stays high until the last such entry has been read.
- R9: After reset the queue is empty, `level` is 0, and `err_any` and `ovf` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Push strobe from the receiver |
| wr_data | input | DATA_W | Character to push |
| wr_flags | input | 3 | Flags of the pushed character: [2] break, [1] framing, [0] parity |
| rd_en | input | 1 | Pop strobe from the host |
| head_data | output | DATA_W | Character at the head (zero when empty) |
| head_flags | output | 3 | Flags of the head character (zero when empty) |
| err_any | output | 1 | High while any stored entry carries an error |
| empty | output | 1 | Queue holds no entries |
| full | output | 1 | Queue holds DEPTH entries |
| level | output | $clog2(DEPTH+1) | Number of stored entries |
| ovf | output | 1 | One-cycle pulse after a discarded write |

## Verification
A wrong error count would show as `err_any` staying high after the last flagged entry has been drained, or dropping while flagged entries remain. The bench sees this at the cycle after the read that should have changed it. A pointer or level slip would show at once as a wrong `head_data` or `head_flags` on the next pop, or as `full` and `empty` disagreeing with the fill count. The bench compares every output against a reference queue after every clock. This covers full-depth fills, overflow at the top, ignored reads at the bottom and long mixed traffic, so a divergence is reported within one cycle of its cause.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int FLAG_W = 3;

   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rxq_flags_t;

   function automatic logic flags_bad(input rxq_flags_t f);
      return f.brk | f.frm | f.par;
   endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int ENTRY_W = 11,
   parameter int DEPTH   = 64,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int PTR_W  = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [PTR_W-1:0]   waddr,
   input  logic [ENTRY_W-1:0] wdata,
   input  logic [PTR_W-1:0]   raddr,
   output logic [ENTRY_W-1:0] rdata
);
   logic [ENTRY_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
   parameter int DEPTH  = 64,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic             rd_req,
   output logic             wr_ok,
   output logic             rd_ok,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [LVL_W-1:0] level,
   output logic             empty,
   output logic             full,
   output logic             ovf
);
   assign empty = (level == '0);
   assign full  = (level == LVL_W'(DEPTH));
   assign wr_ok = wr_req & ~full;
   assign rd_ok = rd_req & ~empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         ovf    <= 1'b0;
      end else begin
         ovf <= wr_req & full;
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/rxq_errcnt.sv
module rxq_errcnt #(
   parameter int DEPTH  = 64,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push_bad,
   input  logic pop_bad,
   output logic any_bad
);
   logic [CNT_W-1:0] bad_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bad_cnt <= '0;
      end else begin
         case ({push_bad, pop_bad})
            2'b10:   bad_cnt <= bad_cnt + 1'b1;
            2'b01:   bad_cnt <= bad_cnt - 1'b1;
            default: bad_cnt <= bad_cnt;
         endcase
      end
   end

   assign any_bad = (bad_cnt != '0);
endmodule

// File: rtl/rxq_err_fifo.sv
module rxq_err_fifo
   import rxq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int PTR_W   = $clog2(DEPTH),
   localparam int LVL_W   = $clog2(DEPTH + 1),
   localparam int ENTRY_W = DATA_W + FLAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        wr_flags,
   input  logic              rd_en,
   output logic [DATA_W-1:0] head_data,
   output logic [2:0]        head_flags,
   output logic              err_any,
   output logic              empty,
   output logic              full,
   output logic [LVL_W-1:0]  level,
   output logic              ovf
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rxq_err_fifo: DEPTH must be a power of two >= 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rxq_err_fifo: DATA_W must be positive");
      end
   endgenerate

   logic               wr_ok, rd_ok;
   logic [PTR_W-1:0]   wr_ptr, rd_ptr;
   logic [ENTRY_W-1:0] raw_head;
   rxq_flags_t         in_flags, top_flags;

   assign in_flags = rxq_flags_t'(wr_flags);

   rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_req(wr_en), .rd_req(rd_en),
      .wr_ok(wr_ok), .rd_ok(rd_ok),
      .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
      .level(level), .empty(empty), .full(full), .ovf(ovf)
   );

   rxq_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(wr_ok), .waddr(wr_ptr), .wdata({in_flags, wr_data}),
      .raddr(rd_ptr), .rdata(raw_head)
   );

   assign top_flags = rxq_flags_t'(raw_head[ENTRY_W-1 -: FLAG_W]);

   rxq_errcnt #(.DEPTH(DEPTH)) u_err (
      .clk(clk), .rst_n(rst_n),
      .push_bad(wr_ok & flags_bad(in_flags)),
      .pop_bad(rd_ok & flags_bad(top_flags)),
      .any_bad(err_any)
   );

   assign head_data  = empty ? '0 : raw_head[DATA_W-1:0];
   assign head_flags = empty ? '0 : top_flags;
endmodule

// File: rtl/rxq_err_fifo_chk.sv
module rxq_err_fifo_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] head_data,
   input logic [2:0]        head_flags,
   input logic              err_any,
   input logic              empty,
   input logic              full,
   input logic [LVL_W-1:0]  level,
   input logic              ovf
);
   // R2
   a_r2_empty_full_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full));
   // R3
   a_r3_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> $past(wr_en && full));
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_en) |=> (full && $stable(level) && ovf));
   // R4
   a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en && !wr_en) |=> empty);
   // R5
   a_r5_level_same: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && !empty && !full) |=> $stable(level));
   // R7
   a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (head_data == '0 && head_flags == '0));
   // R8
   a_r8_empty_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !err_any);
   a_r8_head_err: assert property (@(posedge clk) disable iff (!rst_n)
      (head_flags != '0) |-> err_any);
endmodule

bind rxq_err_fifo rxq_err_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
   .head_data(head_data), .head_flags(head_flags), .err_any(err_any),
   .empty(empty), .full(full), .level(level), .ovf(ovf)
);

// File: tb/rxq_err_fifo_test.sv
`timescale 1ns/1ps
module rxq_err_fifo_test;
   localparam int DW = 8;
   localparam int DEPTH = 64;
   localparam int LW = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [2:0] wr_flags = '0;
   logic [DW-1:0] head_data;
   logic [2:0] head_flags;
   logic err_any, empty, full, ovf;
   logic [LW-1:0] level;

   int tests = 0, fails = 0;
   bit done = 1'b0;
   logic [10:0] model [$];
   bit exp_ovf = 1'b0;

   always #2 clk = ~clk;

   rxq_err_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_flags(wr_flags), .rd_en(rd_en), .head_data(head_data),
      .head_flags(head_flags), .err_any(err_any), .empty(empty),
      .full(full), .level(level), .ovf(ovf)
   );

   function automatic bit model_bad();
      foreach (model[i]) if (model[i][10:8] != 3'b000) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic check_all();
      int n = model.size();
      chk("R1 level", int'(level), n);
      chk("R2 empty", int'(empty), int'(n == 0));
      chk("R2 full", int'(full), int'(n == DEPTH));
      chk("R3 ovf", int'(ovf), int'(exp_ovf));
      chk("R8 err_any", int'(err_any), int'(model_bad()));
      if (n == 0) begin
         chk("R7 head_data zero", int'(head_data), 0);
         chk("R7 head_flags zero", int'(head_flags), 0);
      end else begin
         chk("R1 head_data", int'(head_data), int'(model[0][7:0]));
         chk("R6 head_flags", int'(head_flags), int'(model[0][10:8]));
      end
   endtask

   // called at a falling edge; returns at the next falling edge after checking
   task automatic cyc(input bit w, input logic [7:0] d, input logic [2:0] f, input bit r);
      int n;
      bit acc_w, acc_r;
      wr_en = w; wr_data = d; wr_flags = f; rd_en = r;
      @(posedge clk);
      n = model.size();
      acc_w = w && n < DEPTH;
      acc_r = r && n > 0;
      exp_ovf = w && n == DEPTH;
      if (acc_r) void'(model.pop_front());
      if (acc_w) model.push_back({f, d});
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check_all();
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 level", int'(level), 0);
      chk("R9 empty", int'(empty), 1);
      chk("R9 err_any", int'(err_any), 0);
      chk("R9 ovf", int'(ovf), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_all();

      // R4: read on empty ignored
      cyc(0, 8'h00, 3'b000, 1);
      cyc(0, 8'h00, 3'b000, 1);

      // R1/R2/R6: fill to full, every flag pattern in turn
      for (int i = 0; i < DEPTH; i++)
         cyc(1, 8'(i * 7 + 3), 3'(i % 8), 0);
      // R3: writes on full dropped, one-cycle pulse
      cyc(1, 8'hEE, 3'b111, 0);
      cyc(1, 8'hDD, 3'b000, 0);
      cyc(0, 8'h00, 3'b000, 0);
      // R3/R5 corner: read+write while full -> read only, write dropped
      cyc(1, 8'hCC, 3'b010, 1);
      // R5: read+write when partly full
      cyc(1, 8'h5A, 3'b000, 1);
      // drain fully, then extra read
      for (int i = 0; i < DEPTH + 2; i++) cyc(0, 8'h00, 3'b000, 1);

      // R5 on empty: read ignored, write accepted
      cyc(1, 8'h11, 3'b000, 1);
      cyc(0, 8'h00, 3'b000, 1);

      // R8: sticky summary until last flagged entry leaves
      cyc(1, 8'h21, 3'b100, 0);
      cyc(1, 8'h22, 3'b000, 0);
      cyc(1, 8'h23, 3'b001, 0);
      cyc(1, 8'h24, 3'b000, 0);
      for (int i = 0; i < 5; i++) cyc(0, 8'h00, 3'b000, 1);
      // R8: flagged pop coinciding with flagged push keeps summary
      cyc(1, 8'h31, 3'b010, 0);
      cyc(1, 8'h32, 3'b001, 1);
      cyc(0, 8'h00, 3'b000, 1);

      // mixed traffic
      for (int i = 0; i < 4000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(lfsr[0] | lfsr[5], lfsr[15:8], (lfsr[3:1] == 3'b000) ? lfsr[6:4] : 3'b000,
             lfsr[2] & (lfsr[7] | (i > 2000)));
      end
      for (int i = 0; i < DEPTH + 1; i++) cyc(0, 8'h00, 3'b000, 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule